// File: doc/BRIEF.md
# Multi-Decoder Memory Window Register File

This block is the register file for a set of host-managed memory range decoders. Each decoder has its own group of 32-bit registers. Software sets a range base and a range size at 256 MiB granularity, an interleave granularity and way count, and a 64-bit list word pair. That pair holds either a target list or, in the device-side variant, a device-address skip. Software then commits the decoder by setting a request bit in the decoder's control word. A one-cycle handshake turns the request into a committed flag, or into an error flag when global decoding is switched off.

The decoded fields, the committed flags and the two global enables go straight to downstream address-routing logic. Software reaches the block through a plain valid/write/address/data port. Read data comes back registered, one cycle after the request. A read-only capability word reports the decoder count in encoded form. A global control word holds the poison-on-error enable and the decode enable. While a decoder is committed, its range, interleave and list fields are frozen.

Top module: `mwin_regs`

## Requirements
- R1: After reset every decoder is uncommitted with zero base, size, interleave and list fields. Both global enables are off, and every register except the capability word reads zero.
- R2: The capability word at byte offset 0x00 reports the decoder count encoded in bits 3:0: 0 for one decoder, otherwise the count divided by two (2 for four decoders). All other bits read zero, and writes to it have no effect.
- R3: The global control word at 0x04 holds poison-on-error enable in bit 0 and decode enable in bit 1. Its other bits read zero. Both bits drive the matching output pins.
- R4: Decoder n occupies 0x10 + 0x20*n: base-low +0x00, base-high +0x04, size-low +0x08, size-high +0x0C, control +0x10, list-low +0x14, list-high +0x18. Every other address reads zero, and writes to it change nothing.
- R5: Base-low and size-low keep only bits 31:28. Base-high and size-high keep their low HPA_W-32 bits. The exported range field is {high, low[31:28]}.
- R6: In the target-list variant both list words keep all 32 bits. In the skip variant list-low keeps only bits 31:28 and list-high keeps its low HPA_W-32 bits.
- R7: The control word holds granularity in bits 3:0, way count in bits 7:4 and the commit request in bit 8, all read/write. The committed flag sits in bit 9 and the error flag in bit 10; both are read-only.
- R8: Writing a control word with bit 8 set while decode enable is on sets that decoder's committed flag on the second rising edge after the write edge, and clears its error flag.
- R9: A commit request made while decode enable is off leaves the decoder uncommitted and sets its error flag.
- R10: Writing a control word with bit 8 clear removes the committed flag and clears the error flag, again on the second edge.
- R11: A commit or uncommit acts only on the decoder whose control word was addressed.
- R12: While a decoder is committed, writes to its range words, list words and control bits 7:0 are ignored. The commit request bit stays writable, and after an uncommit the fields are writable again.
- R13: A read request returns its data with rsp_valid high one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address (bits 1:0 ignored) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| poison_en_o | output | 1 | Poison-on-error enable |
| decode_en_o | output | 1 | Global decode enable |
| dec_committed_o | output | NUM_DEC | Committed flag per decoder |
| dec_base_o | output | NUM_DEC*(HPA_W-28) | Range base, upper bits, per decoder |
| dec_size_o | output | NUM_DEC*(HPA_W-28) | Range size, upper bits, per decoder |
| dec_gran_o | output | NUM_DEC*4 | Interleave granularity code per decoder |
| dec_ways_o | output | NUM_DEC*4 | Interleave way code per decoder |
| dec_list_o | output | NUM_DEC*64 | List word pair {high, low} per decoder |

## Verification
The bench builds the default configuration: four decoders and a 52-bit host address, so the high words keep 20 bits. It builds this twice, once as the target-list variant and once as the skip variant, with the same requests driving both. Four decoders are few enough to sweep every register slot of every group, including the unused slot, with several data patterns, and to predict each masked read-back arithmetically. The unused slot and the gaps in the map show whether any group aliases another. The two instances show how the list masking differs between the variants. The commit, refusal, uncommit and lock sequences can then be run across different decoders, so that a decision taken from the wrong group shows up.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

   localparam int unsigned REG_W        = 32;
   localparam int unsigned DEC_BASE_OFS = 'h10;
   localparam int unsigned DEC_STRIDE   = 'h20;

   // control word bit positions
   localparam int unsigned CTL_REQ  = 8;
   localparam int unsigned CTL_DONE = 9;
   localparam int unsigned CTL_ERR  = 10;

   // word slot inside a decoder group
   typedef enum logic [2:0] {
      SUB_BASE_LO = 3'd0,
      SUB_BASE_HI = 3'd1,
      SUB_SIZE_LO = 3'd2,
      SUB_SIZE_HI = 3'd3,
      SUB_CTRL    = 3'd4,
      SUB_LIST_LO = 3'd5,
      SUB_LIST_HI = 3'd6,
      SUB_NONE    = 3'd7
   } sub_e;

   function automatic logic [3:0] enc_count(input int unsigned n);
      return (n == 1) ? 4'd0 : 4'(n / 2);
   endfunction

endpackage

// File: rtl/mwin_global.sv
module mwin_global
   import mwin_pkg::*;
#(
   parameter int unsigned NUM_DEC = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_glb,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] cap_word_o,
   output logic [REG_W-1:0] glb_word_o,
   output logic             poison_en_o,
   output logic             decode_en_o
);

   localparam logic [3:0] CNT_CODE = enc_count(NUM_DEC);

   logic [1:0] glb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glb_q <= '0;
      end else if (wr_glb) begin
         glb_q <= wr_data[1:0];
      end
   end

   assign cap_word_o  = {{(REG_W-4){1'b0}}, CNT_CODE};
   assign glb_word_o  = {{(REG_W-2){1'b0}}, glb_q};
   assign poison_en_o = glb_q[0];
   assign decode_en_o = glb_q[1];

   // R3: the global word only moves on an addressed write
   p_glb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_glb) |-> $stable(glb_q));

endmodule

// File: rtl/mwin_decoder.sv
module mwin_decoder
   import mwin_pkg::*;
#(
   parameter int unsigned HPA_W        = 52,
   parameter bit          SKIP_VARIANT = 1'b0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  sub_e               sub,
   input  logic [REG_W-1:0]   wr_data,
   input  logic               glb_en,
   output logic [REG_W-1:0]   rd_word_o,
   output logic               committed_o,
   output logic [HPA_W-29:0]  base_o,
   output logic [HPA_W-29:0]  size_o,
   output logic [3:0]         gran_o,
   output logic [3:0]         ways_o,
   output logic [2*REG_W-1:0] list_o
);

   localparam int unsigned      HI_W    = HPA_W - 32;
   localparam logic [REG_W-1:0] HI_MASK = REG_W'((64'd1 << HI_W) - 64'd1);
   localparam logic [REG_W-1:0] LO_MASK = 32'hF000_0000;

   logic [3:0]       base_lo_q, size_lo_q;
   logic [HI_W-1:0]  base_hi_q, size_hi_q;
   logic [REG_W-1:0] list_lo_q, list_hi_q;
   logic [3:0]       gran_q, ways_q;
   logic             creq_q, done_q, err_q;
   logic             act_q, act_val_q;
   logic [REG_W-1:0] list_lo_mask, list_hi_mask;
   logic             locked;

   if (SKIP_VARIANT) begin : g_skip
      assign list_lo_mask = LO_MASK;
      assign list_hi_mask = HI_MASK;
   end else begin : g_tgt
      assign list_lo_mask = '1;
      assign list_hi_mask = '1;
   end

   assign locked = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_lo_q <= '0;
         size_lo_q <= '0;
         base_hi_q <= '0;
         size_hi_q <= '0;
         list_lo_q <= '0;
         list_hi_q <= '0;
         gran_q    <= '0;
         ways_q    <= '0;
         creq_q    <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         act_q     <= 1'b0;
         act_val_q <= 1'b0;
      end else begin
         act_q <= 1'b0;
         if (wr_en && sub == SUB_CTRL) begin
            creq_q    <= wr_data[CTL_REQ];
            act_q     <= 1'b1;
            act_val_q <= wr_data[CTL_REQ];
            if (!locked) begin
               gran_q <= wr_data[3:0];
               ways_q <= wr_data[7:4];
            end
         end
         if (wr_en && !locked) begin
            case (sub)
               SUB_BASE_LO: base_lo_q <= wr_data[31:28];
               SUB_BASE_HI: base_hi_q <= wr_data[HI_W-1:0];
               SUB_SIZE_LO: size_lo_q <= wr_data[31:28];
               SUB_SIZE_HI: size_hi_q <= wr_data[HI_W-1:0];
               SUB_LIST_LO: list_lo_q <= wr_data & list_lo_mask;
               SUB_LIST_HI: list_hi_q <= wr_data & list_hi_mask;
               default: ;
            endcase
         end
         // second half of the handshake
         if (act_q) begin
            if (act_val_q) begin
               if (glb_en) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b0;
               end else begin
                  err_q  <= 1'b1;
               end
            end else begin
               done_q <= 1'b0;
               err_q  <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      case (sub)
         SUB_BASE_LO: rd_word_o = {base_lo_q, 28'b0};
         SUB_BASE_HI: rd_word_o = REG_W'(base_hi_q);
         SUB_SIZE_LO: rd_word_o = {size_lo_q, 28'b0};
         SUB_SIZE_HI: rd_word_o = REG_W'(size_hi_q);
         SUB_CTRL:    rd_word_o = {21'b0, err_q, done_q, creq_q, ways_q, gran_q};
         SUB_LIST_LO: rd_word_o = list_lo_q;
         SUB_LIST_HI: rd_word_o = list_hi_q;
         default:     rd_word_o = '0;
      endcase
   end

   assign committed_o = done_q;
   assign base_o      = {base_hi_q, base_lo_q};
   assign size_o      = {size_hi_q, size_lo_q};
   assign gran_o      = gran_q;
   assign ways_o      = ways_q;
   assign list_o      = {list_hi_q, list_lo_q};

   // R8: commit only follows an accepted request with decode enabled
   p_commit_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(act_q && act_val_q && glb_en));

   // R9: error only rises on a refused commit
   p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(act_q && act_val_q && !glb_en));

   // R10: committed status only drops on an uncommit
   p_uncommit_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_q) |-> $past(act_q && !act_val_q));

   // R10: error only clears through the handshake
   p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_q) |-> $past(act_q));

   // R12: fields frozen while committed
   p_lock_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done_q) |-> $stable({base_hi_q, base_lo_q, size_hi_q, size_lo_q,
                                 list_hi_q, list_lo_q, gran_q, ways_q}));

endmodule

// File: rtl/mwin_regs.sv
module mwin_regs
   import mwin_pkg::*;
#(
   parameter int unsigned NUM_DEC      = 4,
   parameter int unsigned HPA_W        = 52,
   parameter int unsigned ADDR_W       = 8,
   parameter bit          SKIP_VARIANT = 1'b0
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [31:0]                   req_wdata,
   output logic                          rsp_valid,
   output logic [31:0]                   rsp_rdata,
   output logic                          poison_en_o,
   output logic                          decode_en_o,
   output logic [NUM_DEC-1:0]            dec_committed_o,
   output logic [NUM_DEC*(HPA_W-28)-1:0] dec_base_o,
   output logic [NUM_DEC*(HPA_W-28)-1:0] dec_size_o,
   output logic [NUM_DEC*4-1:0]          dec_gran_o,
   output logic [NUM_DEC*4-1:0]          dec_ways_o,
   output logic [NUM_DEC*64-1:0]         dec_list_o
);

   localparam int unsigned RNG_W   = HPA_W - 28;
   localparam longint unsigned MAP_END = DEC_BASE_OFS + DEC_STRIDE * NUM_DEC;

   if (NUM_DEC < 1 || NUM_DEC > 30 || (NUM_DEC > 1 && (NUM_DEC % 2) != 0)) begin : g_bad_num
      $error("mwin_regs: NUM_DEC must be 1 or an even count up to 30");
   end
   if (HPA_W < 33 || HPA_W > 64) begin : g_bad_hpa
      $error("mwin_regs: HPA_W must lie in 33..64");
   end
   if (ADDR_W < 6 || ADDR_W > 32 || MAP_END > (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("mwin_regs: ADDR_W cannot cover the decoder map");
   end

   logic [31:0]       addr32;
   logic [ADDR_W-1:0] rel;
   logic              in_dec;
   logic              wr_go, rd_go;
   sub_e              sub;
   logic [NUM_DEC-1:0] hit;
   logic [REG_W-1:0]  dec_rd [NUM_DEC];
   logic [REG_W-1:0]  cap_word, glb_word, rd_mux;
   logic              is_cap, is_glb;

   assign addr32 = 32'(req_addr);
   assign rel    = req_addr - ADDR_W'(DEC_BASE_OFS);
   assign in_dec = (addr32 >= DEC_BASE_OFS) && (64'(addr32) < MAP_END);
   assign sub    = sub_e'(rel[4:2]);
   assign wr_go  = req_valid && req_write;
   assign rd_go  = req_valid && !req_write;
   assign is_cap = (req_addr[ADDR_W-1:2] == '0);
   assign is_glb = (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

   mwin_global #(.NUM_DEC(NUM_DEC)) u_glb (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_glb      (wr_go && is_glb),
      .wr_data     (req_wdata),
      .cap_word_o  (cap_word),
      .glb_word_o  (glb_word),
      .poison_en_o (poison_en_o),
      .decode_en_o (decode_en_o)
   );

   for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
      assign hit[g] = in_dec && (rel[ADDR_W-1:5] == (ADDR_W-5)'(g));

      mwin_decoder #(.HPA_W(HPA_W), .SKIP_VARIANT(SKIP_VARIANT)) u_dec (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_en       (wr_go && hit[g]),
         .sub         (sub),
         .wr_data     (req_wdata),
         .glb_en      (decode_en_o),
         .rd_word_o   (dec_rd[g]),
         .committed_o (dec_committed_o[g]),
         .base_o      (dec_base_o[g*RNG_W +: RNG_W]),
         .size_o      (dec_size_o[g*RNG_W +: RNG_W]),
         .gran_o      (dec_gran_o[g*4 +: 4]),
         .ways_o      (dec_ways_o[g*4 +: 4]),
         .list_o      (dec_list_o[g*64 +: 64])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (is_cap) rd_mux = cap_word;
      if (is_glb) rd_mux = glb_word;
      for (int i = 0; i < NUM_DEC; i++) begin
         if (hit[i]) rd_mux = dec_rd[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_go;
         if (rd_go) rsp_rdata <= rd_mux;
      end
   end

   // R13: a response only follows a read request
   p_rsp_follows_rd_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write));

   // R4: at most one decoder group addressed
   p_one_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot0(hit));

endmodule

// File: tb/tb_mwin_regs.sv
`timescale 1ns/1ps
module tb_mwin_regs;

   localparam int ND = 4;
   localparam int RW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;

   logic rsp_valid, rsp_valid_sk;
   logic [31:0] rsp_rdata, rsp_rdata_sk;
   logic poison, dec_en, poison_sk, dec_en_sk;
   logic [ND-1:0] committed, committed_sk;
   logic [ND*RW-1:0] base_o, size_o, base_sk, size_sk;
   logic [ND*4-1:0] gran_o, ways_o, gran_sk, ways_sk;
   logic [ND*64-1:0] list_o, list_sk;

   int n_cmp = 0, n_bad = 0;
   bit fin = 1'b0;

   logic [31:0] m  [ND][8];
   logic [31:0] ms [ND][8];

   always #2.5 clk = ~clk;

   mwin_regs dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .poison_en_o(poison), .decode_en_o(dec_en),
      .dec_committed_o(committed), .dec_base_o(base_o), .dec_size_o(size_o),
      .dec_gran_o(gran_o), .dec_ways_o(ways_o), .dec_list_o(list_o));

   mwin_regs #(.SKIP_VARIANT(1'b1)) dut_sk (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid_sk),
      .rsp_rdata(rsp_rdata_sk), .poison_en_o(poison_sk), .decode_en_o(dec_en_sk),
      .dec_committed_o(committed_sk), .dec_base_o(base_sk), .dec_size_o(size_sk),
      .dec_gran_o(gran_sk), .dec_ways_o(ways_sk), .dec_list_o(list_sk));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dsk);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      check("R13 rsp_valid", {63'b0, rsp_valid}, 64'd1);
      d = rsp_rdata;
      dsk = rsp_rdata_sk;
   endtask

   function automatic logic [7:0] da(input int n, input int s);
      return 8'(16 + 32 * n + 4 * s);
   endfunction

   // R5 R6: write masks per slot
   function automatic logic [31:0] wmask(input int s, input bit sk);
      case (s)
         0, 2:    return 32'hF000_0000;
         1, 3:    return 32'h000F_FFFF;
         4:       return 32'h0000_00FF;
         5:       return sk ? 32'hF000_0000 : 32'hFFFF_FFFF;
         6:       return sk ? 32'h000F_FFFF : 32'hFFFF_FFFF;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check_exports(input string tag);
      for (int n = 0; n < ND; n++) begin
         check({tag, " R5 base"}, 64'(base_o[n*RW +: RW]), 64'({m[n][1][19:0], m[n][0][31:28]}));
         check({tag, " R5 size"}, 64'(size_o[n*RW +: RW]), 64'({m[n][3][19:0], m[n][2][31:28]}));
         check({tag, " R7 gran"}, 64'(gran_o[n*4 +: 4]), 64'(m[n][4][3:0]));
         check({tag, " R7 ways"}, 64'(ways_o[n*4 +: 4]), 64'(m[n][4][7:4]));
         check({tag, " R6 list"}, list_o[n*64 +: 64], {m[n][6], m[n][5]});
         check({tag, " R6 list skip"}, list_sk[n*64 +: 64], {ms[n][6], ms[n][5]});
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         fin = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d, dsk, v;
      logic [31:0] pats [3];
      pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5C3_96E1;
      for (int n = 0; n < ND; n++)
         for (int s = 0; s < 8; s++) begin m[n][s] = '0; ms[n][s] = '0; end

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 committed", 64'(committed), 64'd0);
      check("R1 enables", {62'b0, dec_en, poison}, 64'd0);
      check_exports("R1");
      for (int n = 0; n < ND; n++)
         for (int s = 0; s < 8; s++) begin
            rd(da(n, s), d, dsk);
            check("R1 decoder word", 64'(d), 64'd0);
         end
      rd(8'h04, d, dsk); check("R1 global word", 64'(d), 64'd0);
      @(negedge clk);
      check("R13 rsp_valid idle", {63'b0, rsp_valid}, 64'd0);

      // R2 capability
      rd(8'h00, d, dsk); check("R2 cap", 64'(d), 64'd2);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, d, dsk); check("R2 cap after write", 64'(d), 64'd2);

      // R3 global control
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, d, dsk); check("R3 global word", 64'(d), 64'd3);
      check("R3 pins", {62'b0, dec_en, poison}, 64'd3);
      wr(8'h04, 32'h0000_0002);
      rd(8'h04, d, dsk); check("R3 global word", 64'(d), 64'd2);
      check("R3 pins", {62'b0, dec_en, poison}, 64'd2);

      // R4 R5 R6 R7 sweep
      for (int r = 0; r < 3; r++) begin
         for (int n = 0; n < ND; n++)
            for (int s = 0; s < 8; s++) begin
               v = pats[r] ^ (32'(n) * 32'h0101_0101) ^ (32'(s) * 32'h1000_0001);
               if (s == 4) v = v & ~32'h100;
               wr(da(n, s), v);
               m[n][s]  = v & wmask(s, 1'b0);
               ms[n][s] = v & wmask(s, 1'b1);
            end
         wr(8'h08, 32'hFFFF_FFFF);
         wr(8'h0C, 32'hFFFF_FFFF);
         wr(8'h90, 32'hFFFF_FFFF);
         for (int n = 0; n < ND; n++)
            for (int s = 0; s < 8; s++) begin
               rd(da(n, s), d, dsk);
               check("R4 R5 R6 R7 readback", 64'(d), 64'(m[n][s]));
               check("R6 readback skip", 64'(dsk), 64'(ms[n][s]));
            end
         rd(8'h08, d, dsk); check("R4 gap word", 64'(d), 64'd0);
         rd(8'h90, d, dsk); check("R4 past map", 64'(d), 64'd0);
         check_exports("R4 sweep");
         check("R7 no commit in sweep", 64'(committed), 64'd0);
      end

      // R8 commit decoder 1
      wr(8'h04, 32'h2);
      wr(da(1, 4), 32'h135); m[1][4] = 32'h35;
      check("R8 latency", 64'(committed), 64'd0);
      @(negedge clk);
      check("R8 committed", 64'(committed), 64'b0010);
      rd(da(1, 4), d, dsk); check("R8 ctrl", 64'(d), 64'h335);

      // R12 lock
      wr(da(1, 0), 32'h7000_0000);
      rd(da(1, 0), d, dsk); check("R12 base locked", 64'(d), 64'(m[1][0]));
      wr(da(1, 5), 32'h1234_5678);
      rd(da(1, 5), d, dsk); check("R12 list locked", 64'(d), 64'(m[1][5]));
      wr(da(1, 4), 32'h1FF);
      rd(da(1, 4), d, dsk); check("R12 ctrl fields locked", 64'(d), 64'h335);
      check_exports("R12");

      // R11 other decoder still writable, unaffected
      wr(da(2, 0), 32'h3000_0000); m[2][0] = 32'h3000_0000; ms[2][0] = 32'h3000_0000;
      rd(da(2, 0), d, dsk); check("R11 dec2 base", 64'(d), 64'h3000_0000);
      check("R11 committed", 64'(committed), 64'b0010);

      // R9 refused commit
      wr(8'h04, 32'h0);
      wr(da(2, 4), 32'h101); m[2][4] = 32'h01;
      @(negedge clk);
      check("R9 not committed", 64'(committed), 64'b0010);
      rd(da(2, 4), d, dsk); check("R9 error set", 64'(d), 64'h501);

      // R10 uncommit clears error
      wr(da(2, 4), 32'h001);
      @(negedge clk);
      rd(da(2, 4), d, dsk); check("R10 error cleared", 64'(d), 64'h001);

      // R8 commit clears error
      wr(da(2, 4), 32'h101);
      wr(8'h04, 32'h2);
      @(negedge clk);
      rd(da(2, 4), d, dsk); check("R9 error again", 64'(d), 64'h501);
      wr(da(2, 4), 32'h101);
      @(negedge clk);
      check("R8 committed dec2", 64'(committed), 64'b0110);
      rd(da(2, 4), d, dsk); check("R8 error cleared", 64'(d), 64'h301);

      // R10 uncommit decoder 1
      wr(da(1, 4), 32'h035);
      check("R10 latency", 64'(committed), 64'b0110);
      @(negedge clk);
      check("R10 uncommitted", 64'(committed), 64'b0100);
      rd(da(1, 4), d, dsk); check("R10 ctrl", 64'(d), 64'h035);
      wr(da(1, 0), 32'h7000_0000); m[1][0] = 32'h7000_0000; ms[1][0] = 32'h7000_0000;
      rd(da(1, 0), d, dsk); check("R12 unlocked write", 64'(d), 64'h7000_0000);

      // R11 decision from addressed decoder only
      wr(da(3, 4), 32'h1AB); m[3][4] = 32'hAB;
      @(negedge clk);
      check("R11 dec3 committed", 64'(committed), 64'b1100);
      check("R11 skip variant same", 64'(committed_sk), 64'b1100);
      rd(da(0, 4), d, dsk); check("R11 dec0 untouched", 64'(d), 64'(m[0][4]));
      rd(da(3, 4), d, dsk); check("R11 dec3 ctrl", 64'(d), 64'h3AB);
      check_exports("R11");

      fin = 1'b1;
      summary();
      $finish;
   end

endmodule